// File: doc/BRIEF.md
# Two-Entry Instruction Address Translation Cache

This block sits between instruction fetch and the large shared translation table. It keeps two 4 KB page translations. A fetch address whose page matches a valid slot gets its physical address back in the same cycle, with no stall. Because the block has its own lookup port, instruction translation runs alongside data-side use of the shared table. Software has no way to read, write or address the block.

When a fetch misses, the block stalls fetch and raises a refill request that carries the page number and address-space tag. It waits for a grant from the shared table. The reply carries a frame base, a page-size mask, a cache attribute and a fault flag. A good reply is narrowed to a 4 KB frame and written into the least-recently-used slot, and the retried fetch then hits. A fault reply goes to fetch as a one-cycle pulse and is not stored. Both slots are cleared on reset, when the current address-space tag changes, and on any write to the shared table. A reply whose request overlapped such a flush is dropped.

Top module: `itlb_micro`

## Requirements
- R1: After reset both slots are invalid, `rf_req`, `fetch_stall` and `fetch_fault` are low, and the first valid fetch misses.
- R2: A valid fetch that matches a valid slot, with no refill outstanding and no flush this cycle, sets `fetch_stall` low in the same cycle. `fetch_pa` is then {stored frame, `fetch_va[11:0]`} and `fetch_attr` is the stored attribute.
- R3: A valid fetch that misses raises `fetch_stall` in the same cycle. From the next cycle `rf_req` is high, with `rf_vpn` = `fetch_va[31:12]` and `rf_asid` = `cur_asid` of the missing cycle. These values hold steady until `rf_gnt`, and `fetch_stall` stays high over the same span.
- R4: In the cycle `rf_gnt` is high, a non-faulting reply is written into the least-recently-used slot, `rf_req` drops at the next edge, and a retry of the same page then hits.
- R5: Replacement state is one bit that names the victim slot. It resets to slot 0. A hit on slot i, or a refill into slot i, makes the other slot the victim.
- R6: The stored frame is `rf_pfn` + (`rf_vpn[11:0]` AND `rf_mask`). Mask bit k set means virtual page bit k lies inside the backing page.
- R7: A grant with `rf_fault` high pulses `fetch_fault` for that cycle. It stores nothing and does not move the replacement bit, so a retry misses again.
- R8: A change of `cur_asid` from its value in the previous cycle suppresses hits in that cycle and clears both slots.
- R9: `bk_write` high suppresses hits in that cycle and clears both slots.
- R10: If a flush condition (R8 or R9) occurs in any cycle from the missing cycle through the grant cycle, the reply is dropped: nothing is stored and `fetch_fault` stays low.
- R11: With `fetch_valid` low and no refill outstanding, `fetch_stall` and `rf_req` stay low and no request starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch address valid this cycle |
| fetch_va | input | 32 | Fetch virtual address |
| cur_asid | input | 8 | Current address-space tag |
| fetch_stall | output | 1 | Fetch must hold and retry |
| fetch_pa | output | 36 | Translated physical address (zero when no hit) |
| fetch_attr | output | 3 | Cache attribute of the hit page |
| fetch_fault | output | 1 | Shared table reported no translation |
| bk_write | input | 1 | Shared table written this cycle |
| rf_req | output | 1 | Refill request |
| rf_vpn | output | 20 | Requested virtual page number |
| rf_asid | output | 8 | Address-space tag of the request |
| rf_gnt | input | 1 | Refill reply valid |
| rf_pfn | input | 24 | Frame base of the backing page |
| rf_mask | input | 12 | Backing page-size mask in 4 KB units |
| rf_attr | input | 3 | Cache attribute of the reply |
| rf_fault | input | 1 | Reply is a translation fault |

## Verification
The bench targets replacement order. A design that updated the victim bit only on refills, and not on hits, would evict the page just used, and a later fetch of that page would stall where a hit is expected. It covers flushes that land in the same cycle as a hit or inside a refill window: a design that let the old slot answer, or stored a reply already out of date, would return a stale address. It covers fault replies, which a wrong design would store and then hit on. It uses reply masks of several sizes, so wrong frame narrowing shows up as a wrong `fetch_pa`.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 36;
    localparam int ASID_W = 8;
    localparam int ATTR_W = 3;
    localparam int PG_SH  = 12;
    localparam int MASK_W = 12;
    localparam int N_ENT  = 2;

    localparam int VPN_W = VA_W - PG_SH;
    localparam int PFN_W = PA_W - PG_SH;
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    typedef logic [VPN_W-1:0]  vpn_t;
    typedef logic [PFN_W-1:0]  pfn_t;
    typedef logic [ASID_W-1:0] asid_t;
    typedef logic [ATTR_W-1:0] attr_t;
    typedef logic [MASK_W-1:0] mask_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic  vld;
        vpn_t  vpn;
        pfn_t  pfn;
        attr_t attr;
    } uent_t;

    typedef enum logic {RF_IDLE, RF_WAIT} rf_st_e;

    // Narrow a backing page to the 4 KB frame that holds the given page.
    function automatic pfn_t narrow_frame(pfn_t base, vpn_t vpn, mask_t mask);
        return base + pfn_t'(vpn[MASK_W-1:0] & mask);
    endfunction
endpackage

// File: rtl/itlb_entry_array.sv
module itlb_entry_array
    import itlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  idx_t             wr_idx,
    input  vpn_t             wr_vpn,
    input  pfn_t             wr_pfn,
    input  attr_t            wr_attr,
    input  vpn_t             lk_vpn,
    output logic [N_ENT-1:0] match,
    output pfn_t             rd_pfn,
    output attr_t            rd_attr,
    output idx_t             rd_idx
);
    pfn_t  pfn_a  [N_ENT];
    attr_t attr_a [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        uent_t e_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                e_q <= '0;
            end else if (flush) begin
                e_q.vld <= 1'b0;
            end else if (wr_en && wr_idx == idx_t'(g)) begin
                e_q <= '{vld: 1'b1, vpn: wr_vpn, pfn: wr_pfn, attr: wr_attr};
            end
        end
        assign match[g]  = e_q.vld && (e_q.vpn == lk_vpn);
        assign pfn_a[g]  = e_q.pfn;
        assign attr_a[g] = e_q.attr;
    end

    always_comb begin
        rd_idx  = '0;
        rd_pfn  = '0;
        rd_attr = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (match[i]) begin
                rd_idx  = idx_t'(i);
                rd_pfn  = pfn_a[i];
                rd_attr = attr_a[i];
            end
        end
    end

    AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R2
endmodule

// File: rtl/itlb_lru.sv
module itlb_lru
    import itlb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic use_en,
    input  idx_t use_idx,
    output idx_t victim
);
    always_ff @(posedge clk) begin
        if (rst) begin
            victim <= '0;
        end else if (use_en) begin
            victim <= ~use_idx;
        end
    end
endmodule

// File: rtl/itlb_refill_ctl.sv
module itlb_refill_ctl
    import itlb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  miss,
    input  logic  flush_now,
    input  vpn_t  lk_vpn,
    input  asid_t lk_asid,
    input  logic  rf_gnt,
    input  logic  rf_fault,
    output logic  busy,
    output logic  rf_req,
    output vpn_t  rf_vpn,
    output asid_t rf_asid,
    output logic  install_en,
    output logic  fault_out
);
    rf_st_e st_q;
    logic   stale_q;
    logic   discard;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= RF_IDLE;
            stale_q <= 1'b0;
            rf_vpn  <= '0;
            rf_asid <= '0;
        end else begin
            case (st_q)
                RF_IDLE: if (miss) begin
                    st_q    <= RF_WAIT;
                    rf_vpn  <= lk_vpn;
                    rf_asid <= lk_asid;
                    stale_q <= flush_now;
                end
                RF_WAIT: begin
                    if (flush_now) stale_q <= 1'b1;
                    if (rf_gnt)    st_q    <= RF_IDLE;
                end
                default: st_q <= RF_IDLE;
            endcase
        end
    end

    assign busy       = (st_q == RF_WAIT);
    assign rf_req     = busy;
    assign discard    = stale_q || flush_now;
    assign install_en = busy && rf_gnt && !rf_fault && !discard;
    assign fault_out  = busy && rf_gnt && rf_fault && !discard;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        rf_req && !rf_gnt |=> rf_req && $stable(rf_vpn) && $stable(rf_asid)); // R3
    AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rf_req && rf_gnt |=> !rf_req); // R4
endmodule

// File: rtl/itlb_micro.sv
module itlb_micro
    import itlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [VA_W-1:0]   fetch_va,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              fetch_stall,
    output logic [PA_W-1:0]   fetch_pa,
    output logic [ATTR_W-1:0] fetch_attr,
    output logic              fetch_fault,
    input  logic              bk_write,
    output logic              rf_req,
    output logic [VPN_W-1:0]  rf_vpn,
    output logic [ASID_W-1:0] rf_asid,
    input  logic              rf_gnt,
    input  logic [PFN_W-1:0]  rf_pfn,
    input  logic [MASK_W-1:0] rf_mask,
    input  logic [ATTR_W-1:0] rf_attr,
    input  logic              rf_fault
);
    asid_t            asid_q;
    logic             flush_now;
    logic [N_ENT-1:0] match;
    pfn_t             rd_pfn;
    attr_t            rd_attr;
    idx_t             rd_idx;
    idx_t             victim;
    logic             busy, hit, miss, install_en;
    vpn_t             lk_vpn;
    pfn_t             fill_pfn;

    always_ff @(posedge clk) begin
        if (rst) asid_q <= '0;
        else     asid_q <= cur_asid;
    end

    assign lk_vpn    = fetch_va[VA_W-1:PG_SH];
    assign flush_now = bk_write || (cur_asid != asid_q);
    assign hit       = fetch_valid && !busy && !flush_now && (|match);
    assign miss      = fetch_valid && !busy && !hit;
    assign fill_pfn  = narrow_frame(rf_pfn, rf_vpn, rf_mask);

    itlb_entry_array u_arr (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush_now),
        .wr_en   (install_en),
        .wr_idx  (victim),
        .wr_vpn  (rf_vpn),
        .wr_pfn  (fill_pfn),
        .wr_attr (rf_attr),
        .lk_vpn  (lk_vpn),
        .match   (match),
        .rd_pfn  (rd_pfn),
        .rd_attr (rd_attr),
        .rd_idx  (rd_idx)
    );

    itlb_lru u_lru (
        .clk     (clk),
        .rst     (rst),
        .use_en  (hit || install_en),
        .use_idx (install_en ? victim : rd_idx),
        .victim  (victim)
    );

    itlb_refill_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .miss       (miss),
        .flush_now  (flush_now),
        .lk_vpn     (lk_vpn),
        .lk_asid    (cur_asid),
        .rf_gnt     (rf_gnt),
        .rf_fault   (rf_fault),
        .busy       (busy),
        .rf_req     (rf_req),
        .rf_vpn     (rf_vpn),
        .rf_asid    (rf_asid),
        .install_en (install_en),
        .fault_out  (fetch_fault)
    );

    assign fetch_stall = busy || miss;
    assign fetch_pa    = hit ? {rd_pfn, fetch_va[PG_SH-1:0]} : '0;
    assign fetch_attr  = hit ? rd_attr : '0;

    AST_STALL_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        fetch_valid && !hit |-> fetch_stall); // R3
    AST_LRU_AWAY_HIT: assert property (@(posedge clk) disable iff (rst)
        hit |=> victim != $past(rd_idx)); // R5
    AST_LRU_AWAY_FILL: assert property (@(posedge clk) disable iff (rst)
        install_en |=> victim != $past(victim)); // R5
    AST_FAULT_KEEPS_LRU: assert property (@(posedge clk) disable iff (rst)
        fetch_fault |=> $stable(victim)); // R7
    AST_WRITE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        bk_write |=> match == '0); // R9
    AST_NO_FILL_ON_FLUSH: assert property (@(posedge clk) disable iff (rst)
        flush_now |-> !install_en); // R10
endmodule

// File: tb/itlb_micro_tb_top.sv
`timescale 1ns/1ps
module itlb_micro_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_va = '0;
    logic [7:0]  cur_asid = '0;
    logic        fetch_stall, fetch_fault;
    logic [35:0] fetch_pa;
    logic [2:0]  fetch_attr;
    logic        bk_write = 1'b0;
    logic        rf_req;
    logic [19:0] rf_vpn;
    logic [7:0]  rf_asid;
    logic        rf_gnt = 1'b0;
    logic [23:0] rf_pfn = '0;
    logic [11:0] rf_mask = '0;
    logic [2:0]  rf_attr = '0;
    logic        rf_fault = 1'b0;

    always #4 clk = ~clk;

    itlb_micro dut_i (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_va(fetch_va),
        .cur_asid(cur_asid), .fetch_stall(fetch_stall), .fetch_pa(fetch_pa),
        .fetch_attr(fetch_attr), .fetch_fault(fetch_fault), .bk_write(bk_write),
        .rf_req(rf_req), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_gnt(rf_gnt),
        .rf_pfn(rf_pfn), .rf_mask(rf_mask), .rf_attr(rf_attr), .rf_fault(rf_fault)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // bench reference state
    logic        m_v   [2];
    logic [19:0] m_vpn [2];
    logic [23:0] m_pfn [2];
    logic [2:0]  m_att [2];
    logic        m_lru, m_wait, m_stale;
    logic [19:0] m_rvpn;
    logic [7:0]  m_rasid, m_aq;
    logic        last_hit;

    function automatic logic [11:0] rsp_mask(logic [19:0] v);
        case (v[5:4])
            2'd0: return 12'h000;
            2'd1: return 12'h003;
            2'd2: return 12'h0ff;
            default: return 12'hfff;
        endcase
    endfunction
    function automatic logic [23:0] rsp_base(logic [19:0] v, logic [7:0] a);
        logic [23:0] raw;
        raw = ({4'h0, v} * 24'd9) ^ {8'h0, a, 8'h5a};
        return raw & ~{12'h0, rsp_mask(v)};
    endfunction
    function automatic logic [2:0] rsp_attr(logic [19:0] v, logic [7:0] a);
        return v[2:0] ^ a[2:0];
    endfunction
    function automatic logic rsp_fault(logic [19:0] v);
        return v[3:0] == 4'hD;
    endfunction
    function automatic logic [19:0] pool(int k);
        return 20'h12340 + 20'(k) * 20'h1B;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_v[i] = 1'b0; m_vpn[i] = '0; m_pfn[i] = '0; m_att[i] = '0;
        end
        m_lru = 1'b0; m_wait = 1'b0; m_stale = 1'b0;
        m_rvpn = '0; m_rasid = '0; m_aq = '0;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // One cycle: drive at negedge, compare before posedge, advance model after it.
    task automatic step(input logic fv, input logic [31:0] va, input logic [7:0] asid,
                        input logic jw, input logic gnt, input string tag);
        logic        fn, hit, miss, f, inst, exp_stall, exp_fault, hidx, g;
        logic [1:0]  mt;
        logic [19:0] vpn;
        @(negedge clk);
        g = gnt && m_wait;
        fetch_valid = fv; fetch_va = va; cur_asid = asid; bk_write = jw; rf_gnt = g;
        rf_pfn   = rsp_base(m_rvpn, m_rasid);
        rf_mask  = rsp_mask(m_rvpn);
        rf_attr  = rsp_attr(m_rvpn, m_rasid);
        rf_fault = rsp_fault(m_rvpn);
        #1;
        vpn = va[31:12];
        fn  = jw || (asid != m_aq);
        for (int i = 0; i < 2; i++) mt[i] = m_v[i] && (m_vpn[i] == vpn);
        hit  = fv && !m_wait && !fn && (mt != 2'b00);
        hidx = mt[1];
        miss = fv && !m_wait && !hit;
        f    = rf_fault;
        exp_stall = m_wait || miss;
        exp_fault = m_wait && g && f && !(m_stale || fn);
        inst      = m_wait && g && !f && !(m_stale || fn);
        last_hit  = hit;
        chk(fetch_stall === exp_stall, tag, "stall", 64'(fetch_stall), 64'(exp_stall));
        chk(rf_req === m_wait, tag, "req", 64'(rf_req), 64'(m_wait));
        if (m_wait) begin
            chk(rf_vpn === m_rvpn, tag, "req_vpn", 64'(rf_vpn), 64'(m_rvpn));
            chk(rf_asid === m_rasid, tag, "req_asid", 64'(rf_asid), 64'(m_rasid));
        end
        chk(fetch_fault === exp_fault, tag, "fault", 64'(fetch_fault), 64'(exp_fault));
        if (hit) begin
            chk(fetch_pa === {m_pfn[hidx], va[11:0]}, tag, "pa", 64'(fetch_pa),
                64'({m_pfn[hidx], va[11:0]}));
            chk(fetch_attr === m_att[hidx], tag, "attr", 64'(fetch_attr), 64'(m_att[hidx]));
        end
        @(posedge clk);
        m_aq = asid;
        if (inst) begin
            m_v[m_lru]   = 1'b1;
            m_vpn[m_lru] = m_rvpn;
            m_pfn[m_lru] = rsp_base(m_rvpn, m_rasid) + {12'h0, m_rvpn[11:0] & rsp_mask(m_rvpn)};
            m_att[m_lru] = rsp_attr(m_rvpn, m_rasid);
            m_lru = !m_lru;
        end else if (hit) begin
            m_lru = !hidx;
        end
        if (fn) begin m_v[0] = 1'b0; m_v[1] = 1'b0; end
        if (m_wait) begin
            if (fn) m_stale = 1'b1;
            if (g)  m_wait  = 1'b0;
        end else if (miss) begin
            m_wait = 1'b1; m_rvpn = vpn; m_rasid = asid; m_stale = fn;
        end
    endtask

    // Fetch a page, granting after one wait cycle, until the refill is done.
    task automatic load_page(input logic [19:0] v, input logic [7:0] a, input string tag);
        step(1'b1, {v, 12'h111}, a, 1'b0, 1'b0, tag);
        step(1'b1, {v, 12'h111}, a, 1'b0, 1'b0, tag);
        step(1'b1, {v, 12'h111}, a, 1'b0, 1'b1, tag);
    endtask

    localparam logic [7:0] A0 = 8'h05;

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(fetch_stall === 1'b0, "R1", "stall after reset", 64'(fetch_stall), 0);
        chk(rf_req === 1'b0, "R1", "req after reset", 64'(rf_req), 0);
        chk(fetch_fault === 1'b0, "R1", "fault after reset", 64'(fetch_fault), 0);
        step(1'b0, '0, A0, 1'b0, 1'b0, "R1");           // settle tag
        // R11: idle fetch makes no request
        for (int i = 0; i < 4; i++) step(1'b0, {pool(0), 12'h0}, A0, 1'b0, 1'b0, "R11");
        // R1 / R3: first fetch misses and requests
        step(1'b1, {pool(0), 12'h0AB}, A0, 1'b0, 1'b0, "R1");
        step(1'b1, {pool(0), 12'h0AB}, A0, 1'b0, 1'b0, "R3");
        step(1'b1, {pool(0), 12'h0AB}, A0, 1'b0, 1'b1, "R4");
        step(1'b1, {pool(0), 12'h0AB}, A0, 1'b0, 1'b0, "R2");
        // R5: LRU ordering (A in slot 0, B in slot 1, touch A, C evicts B)
        load_page(pool(3), A0, "R4");
        step(1'b1, {pool(3), 12'hFFF}, A0, 1'b0, 1'b0, "R2");
        step(1'b1, {pool(0), 12'h001}, A0, 1'b0, 1'b0, "R5");
        load_page(pool(2), A0, "R5");
        step(1'b1, {pool(0), 12'h002}, A0, 1'b0, 1'b0, "R5");
        step(1'b1, {pool(3), 12'h003}, A0, 1'b0, 1'b0, "R5");
        step(1'b1, {pool(3), 12'h003}, A0, 1'b0, 1'b1, "R5");
        // R6: wide masks (pool 2 has mask 0xfff, pool 4 has 0x0ff)
        load_page(pool(4), A0, "R6");
        step(1'b1, {pool(4), 12'h7C0}, A0, 1'b0, 1'b0, "R6");
        // R7: fault reply passed through, not stored
        load_page(pool(7), A0, "R7");
        step(1'b1, {pool(7), 12'h000}, A0, 1'b0, 1'b0, "R7");
        step(1'b1, {pool(7), 12'h000}, A0, 1'b0, 1'b1, "R7");
        // R8: address-space change flushes
        load_page(pool(1), A0, "R8");
        step(1'b1, {pool(1), 12'h010}, A0, 1'b0, 1'b0, "R8");
        step(1'b1, {pool(1), 12'h010}, 8'h06, 1'b0, 1'b0, "R8");
        step(1'b1, {pool(1), 12'h010}, 8'h06, 1'b0, 1'b1, "R8");
        step(1'b1, {pool(1), 12'h010}, 8'h06, 1'b0, 1'b0, "R8");
        // R9: write to the shared table flushes
        step(1'b1, {pool(1), 12'h020}, 8'h06, 1'b1, 1'b0, "R9");
        step(1'b1, {pool(1), 12'h020}, 8'h06, 1'b0, 1'b1, "R9");
        step(1'b1, {pool(1), 12'h020}, 8'h06, 1'b0, 1'b0, "R9");
        // R10: flush inside refill window drops the reply
        step(1'b1, {pool(5), 12'h0}, 8'h06, 1'b0, 1'b0, "R10");
        step(1'b1, {pool(5), 12'h0}, 8'h06, 1'b1, 1'b0, "R10");
        step(1'b1, {pool(5), 12'h0}, 8'h06, 1'b0, 1'b1, "R10");
        step(1'b1, {pool(5), 12'h0}, 8'h06, 1'b0, 1'b0, "R10");
        step(1'b1, {pool(5), 12'h0}, 8'h06, 1'b0, 1'b1, "R10");
        step(1'b1, {pool(5), 12'h0}, 8'h06, 1'b1, 1'b1, "R10");
        // constrained random mix
        begin
            logic [7:0] asid = 8'h06;
            for (int n = 0; n < 3000; n++) begin
                int k;
                logic fv, jw, gn;
                k  = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 3);
                fv = ($urandom % 8) != 0;
                jw = ($urandom % 50) == 0;
                gn = ($urandom % 3) == 0;
                if (($urandom % 40) == 0) asid = asid ^ 8'h03;
                step(fv, {pool(k), 12'($urandom)}, asid, jw, gn, "R2");
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule